// File: doc/BRIEF.md
# Register-File LIFO Stack

This block is a last-in first-out store of 64 words. The words sit in a register array inside the block, and a 6-bit stack pointer addresses them. A push strobe places the write word on top of the stack. A pop strobe returns the top word. One output register carries the word most recently pushed or popped, so the caller reads a popped value on `rdData` one cycle after the pop strobe.

The pointer always names the current top item. A push moves the pointer up by one first and then writes at the new position. A pop reads at the pointer and then moves it down by one. The full flag is taken from the pointer wrapping to zero after a push, not from an occupancy counter. The empty flag is set when a pop brings the pointer back to zero.

An operation that cannot be carried out changes nothing in the stack and raises `errPulse` for one cycle. Such operations are a push while full, a pop while empty, or a push and a pop in the same cycle.

Top module: `reg_lifo_top`

## Requirements
- R1: After reset, `isEmpty` is 1, `isFull` is 0, `errPulse` is 0 and `rdData` is 0.
- R2: A legal push sets `rdData` to the pushed word and clears `isEmpty` on the next cycle.
- R3: `isFull` rises only after the 64th stored word: it is 0 with 63 words held and 1 with 64 words held.
- R4: A legal pop places the most recently pushed word that is still held on `rdData` on the next cycle, and it clears `isFull`.
- R5: A pop that removes the last held word sets `isEmpty` to 1.
- R6: A push while `isFull` is 1 leaves the stack contents and flags unchanged and raises `errPulse`.
- R7: A pop while `isEmpty` is 1 leaves `rdData` and the flags unchanged and raises `errPulse`.
- R8: A push and a pop strobed in the same cycle are both ignored, whatever the fill level, and raise `errPulse`.
- R9: `errPulse` is high for exactly the one cycle after an illegal request and is low after any legal request or idle cycle.
- R10: `isFull` and `isEmpty` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushReq | input | 1 | Push strobe |
| popReq | input | 1 | Pop strobe |
| wrData | input | 16 | Word to push |
| rdData | output | 16 | Last pushed or popped word |
| isFull | output | 1 | Stack holds 64 words |
| isEmpty | output | 1 | Stack holds no words |
| errPulse | output | 1 | One-cycle pulse after an illegal request |

## Verification
A push and a pop can both be requested in the same cycle. The bench provokes this with an empty stack, with a partly filled stack and with a full stack. Each time it checks that `rdData`, both flags and the later pop order are unchanged, and that `errPulse` rises for the one cycle. Random traffic also produces such collisions. A behavioural queue model judges every cycle of it.

// File: rtl/reg_lifo_pkg.sv
package reg_lifo_pkg;
  typedef struct packed {
    logic doPush;
    logic doPop;
  } lifo_strobe_t;
endpackage

// File: rtl/reg_lifo_ctrl.sv
module reg_lifo_ctrl #(
  parameter int PTR_W = 6
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         pushReq,
  input  logic                         popReq,
  input  logic [PTR_W-1:0]             sp,
  output reg_lifo_pkg::lifo_strobe_t   strobe,
  output logic                         isFull,
  output logic                         isEmpty,
  output logic                         errPulse
);
  localparam logic [PTR_W-1:0] SP_LAST = '1;
  localparam logic [PTR_W-1:0] SP_ONE  = PTR_W'(1);

  logic illegal;

  always_comb begin
    strobe.doPush = pushReq && !popReq && !isFull;
    strobe.doPop  = popReq && !pushReq && !isEmpty;
    illegal       = (pushReq && popReq) || (pushReq && isFull) || (popReq && isEmpty);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      isFull   <= 1'b0;
      isEmpty  <= 1'b1;
      errPulse <= 1'b0;
    end else begin
      errPulse <= illegal;
      if (strobe.doPush) begin
        isEmpty <= 1'b0;
        if (sp == SP_LAST) isFull <= 1'b1;
      end else if (strobe.doPop) begin
        isFull <= 1'b0;
        if (sp == SP_ONE) isEmpty <= 1'b1;
      end
    end
  end

  p_flags_exclusive_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(isFull && isEmpty));
  p_full_at_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    isFull |-> (sp == '0));
  p_push_full_err_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && isFull) |=> (errPulse && isFull));
  p_pop_empty_err_r7: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && isEmpty) |=> (errPulse && isEmpty));
  p_both_err_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && popReq) |=> errPulse);
  p_no_err_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!pushReq && !popReq) |=> !errPulse);
endmodule

// File: rtl/reg_lifo_dp.sv
module reg_lifo_dp #(
  parameter int DATA_W = 16,
  parameter int PTR_W  = 6
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  reg_lifo_pkg::lifo_strobe_t  strobe,
  input  logic [DATA_W-1:0]           wrData,
  output logic [PTR_W-1:0]            sp,
  output logic [DATA_W-1:0]           rdData
);
  localparam int DEPTH = 1 << PTR_W;

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  spUp;
  logic [PTR_W-1:0]  spDown;

  always_comb begin
    spUp   = sp + 1'b1;
    spDown = sp - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strobe.doPush) store[spUp] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sp     <= '0;
      rdData <= '0;
    end else if (strobe.doPush) begin
      sp     <= spUp;
      rdData <= wrData;
    end else if (strobe.doPop) begin
      rdData <= store[sp];
      sp     <= spDown;
    end
  end

  p_push_data_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doPush |=> (rdData == $past(wrData)));
  p_sp_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.doPush && !strobe.doPop) |=> ($stable(sp) && $stable(rdData)));
  p_push_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doPush |=> (sp == PTR_W'($past(sp) + 1'b1)));
endmodule

// File: rtl/reg_lifo_top.sv
module reg_lifo_top #(
  parameter int DATA_W = 16,
  parameter int PTR_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushReq,
  input  logic              popReq,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              isFull,
  output logic              isEmpty,
  output logic              errPulse
);
  reg_lifo_pkg::lifo_strobe_t strobe;
  logic [PTR_W-1:0]           sp;

  reg_lifo_ctrl #(.PTR_W(PTR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .pushReq(pushReq), .popReq(popReq), .sp(sp),
    .strobe(strobe), .isFull(isFull), .isEmpty(isEmpty), .errPulse(errPulse)
  );

  reg_lifo_dp #(.DATA_W(DATA_W), .PTR_W(PTR_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .sp(sp), .rdData(rdData)
  );
endmodule

// File: tb/reg_lifo_top_tb_top.sv
module reg_lifo_top_tb_top;
  localparam int DW = 16;
  localparam int CAP = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushReq = 1'b0;
  logic popReq = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic isFull, isEmpty, errPulse;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [DW-1:0] model [$];
  logic [DW-1:0] expData = '0;
  logic expErr = 1'b0;

  always #2 clk = ~clk;

  reg_lifo_top dut_i (
    .clk(clk), .rstN(rstN), .pushReq(pushReq), .popReq(popReq), .wrData(wrData),
    .rdData(rdData), .isFull(isFull), .isEmpty(isEmpty), .errPulse(errPulse)
  );

  task automatic compare(input string tag);
    logic eFull, eEmpty;
    eFull  = (model.size() == CAP);
    eEmpty = (model.size() == 0);
    checks++;
    if (rdData !== expData || isFull !== eFull || isEmpty !== eEmpty || errPulse !== expErr) begin
      errors++;
      $display("FAIL %s: got data=%h full=%b empty=%b err=%b, expected data=%h full=%b empty=%b err=%b",
               tag, rdData, isFull, isEmpty, errPulse, expData, eFull, eEmpty, expErr);
    end
  endtask

  task automatic step(input logic pu, input logic po, input logic [DW-1:0] wd, input string tag);
    pushReq = pu; popReq = po; wrData = wd;
    @(posedge clk);
    if (pu && po) expErr = 1'b1;
    else if (pu) begin
      if (model.size() == CAP) expErr = 1'b1;
      else begin model.push_back(wd); expData = wd; expErr = 1'b0; end
    end else if (po) begin
      if (model.size() == 0) expErr = 1'b1;
      else begin expData = model.pop_back(); expErr = 1'b0; end
    end else expErr = 1'b0;
    @(negedge clk);
    pushReq = 1'b0; popReq = 1'b0;
    compare(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    compare("R1 reset state");
    step(1, 0, 16'h1111, "R2 push first");
    step(1, 0, 16'h2222, "R2 push second");
    step(1, 0, 16'h3333, "R2 push third");
    step(0, 0, 16'h0, "R9 idle clears err");
    step(1, 1, 16'hdead, "R8 collision partly filled");
    step(0, 1, 16'h0, "R4 pop top");
    step(0, 1, 16'h0, "R4 pop middle");
    step(0, 1, 16'h0, "R5 pop last sets empty");
    step(0, 1, 16'h0, "R7 pop on empty");
    step(1, 1, 16'hbeef, "R8 collision when empty");
    step(0, 0, 16'h0, "R9 err is one cycle");
    for (int i = 0; i < CAP - 1; i++) step(1, 0, DW'(16'h4000 + i), "R3 fill");
    step(0, 0, 16'h0, "R3 not full at 63 words");
    step(1, 0, 16'h5aa5, "R3 full at 64 words");
    step(1, 0, 16'hffff, "R6 push on full");
    step(1, 1, 16'hcccc, "R8 collision when full");
    step(0, 1, 16'h0, "R4 pop clears full");
    step(1, 0, 16'h7777, "R2 refill");
    for (int i = 0; i < CAP; i++) step(0, 1, 16'h0, "R4 R10 drain order");
    step(0, 1, 16'h0, "R7 pop after drain");
    for (int i = 0; i < 600; i++) begin
      logic [1:0] r;
      r = 2'($urandom_range(0, 3));
      step(r[0], r[1], DW'($urandom), "R9 random traffic");
    end
    done = 1'b1;
  end

  initial begin
    while (!done && cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule